// File: doc/BRIEF.md
# Banked I/O Video Memory Window

This block sits on the I/O side of an 8-bit processor bus that has a 16-bit address. It lets software reach a separate 20 KB video memory using only I/O instructions. A write to one 8-bit enable port turns on a bank mode. While that mode is on, every I/O write is stored in video memory instead of going to a peripheral. The byte address comes from the lower 15 bits of the I/O address bus. A read of one full 16-bit disable address turns the mode off again.

The lowest 512 bytes of the video memory hold the palette, and pixel data starts at offset 0x200. The window does not treat the two regions differently. Any window address at or beyond 20 KB is not stored, and a sticky overflow flag records that it happened. While the mode is off, I/O writes to any other port go out on a separate peripheral write strobe. All outputs are registered, so they appear one clock after the bus strobe is sampled. Reset is asynchronous and active low, and its release is synchronised to the clock inside the block.

Top module: `vram_io_window`

## Requirements
- R1: While reset is held, and after it is released until the first access, bank_on, vram_we, periph_we and vram_ovf are all 0.
- R2: With the mode off, an I/O write whose address bits 7:0 equal 0xC8 sets bank_on one clock later. Address bits 15:8 and the data value do not matter. This write produces neither vram_we nor periph_we.
- R3: With the mode on, an I/O write whose address bits 14:0 are below 20480 (0x5000) pulses vram_we one clock later. In that cycle vram_addr equals address bits 14:0 and vram_wdata equals the written byte. Address bit 15 is ignored.
- R4: With the mode on, a write to low port 0xC8 is stored in video memory like any other write, and bank_on stays 1.
- R5: With the mode on, a read of address 0x7FFF (all 16 bits compared) clears bank_on one clock later. A read of any other address leaves the mode on.
- R6: With the mode off, a read of 0x7FFF has no effect: bank_on stays 0 and no write strobe appears.
- R7: With the mode on, a write whose address bits 14:0 are 20480 or more is discarded, so vram_we stays 0. vram_ovf is set one clock later and stays 1 until reset.
- R8: With the mode off, an I/O write whose low byte is not 0xC8 pulses periph_we one clock later. In that cycle periph_port equals address bits 7:0 and periph_wdata equals the data. vram_we stays 0.
- R9: I/O reads never produce vram_we or periph_we, and the two write strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O address bus |
| io_wdata | input | 8 | I/O write data bus |
| io_rd | input | 1 | I/O read strobe, one access per high clock cycle |
| io_wr | input | 1 | I/O write strobe, one access per high clock cycle |
| vram_we | output | 1 | Video memory write enable pulse |
| vram_addr | output | 15 | Video memory byte address |
| vram_wdata | output | 8 | Video memory write data |
| periph_we | output | 1 | Peripheral write pulse, used while the mode is off |
| periph_port | output | 8 | Peripheral port number |
| periph_wdata | output | 8 | Peripheral write data |
| bank_on | output | 1 | Bank mode flag |
| vram_ovf | output | 1 | Sticky flag for a discarded write beyond 20 KB |

## Verification
With the mode off, the bench writes to all 256 low port numbers, each with a different upper address byte. This separates the enable decode from peripheral pass-through and shows that the enable match ignores the upper bits. With the mode on, a stepped sweep covers the whole window. It includes addresses with bit 15 set and the edges 0x0000, 0x01FF, 0x0200, 0x4FFF and 0x5000, which separates stored writes from discarded ones and checks that address bit 15 is ignored. The bench also issues reads of 0x7FFF, of near misses such as 0x7FFE and 0xFFFF, and of other addresses in both modes. These reads show that only the exact 16-bit match clears the flag, and only while it is set.

// File: rtl/vw_pkg.sv
package vw_pkg;
  localparam int unsigned VW_ADDR_W   = 16;
  localparam int unsigned VW_DATA_W   = 8;
  localparam int unsigned VW_PORT_W   = 8;
  localparam int unsigned VW_WIN_W    = 15;
  localparam int unsigned VW_MEM_SIZE = 20480;

  typedef enum logic [1:0] {
    ACC_NONE   = 2'd0,
    ACC_VRAM   = 2'd1,
    ACC_PERIPH = 2'd2,
    ACC_DROP   = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/vw_decode.sv
module vw_decode
  import vw_pkg::*;
#(
  parameter int unsigned ADDR_W   = VW_ADDR_W,
  parameter int unsigned PORT_W   = VW_PORT_W,
  parameter int unsigned WIN_W    = VW_WIN_W,
  parameter int unsigned MEM_SIZE = VW_MEM_SIZE,
  parameter logic [PORT_W-1:0] EN_PORT  = 8'hC8,
  parameter logic [ADDR_W-1:0] DIS_ADDR = 16'h7FFF
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic              bank_on,
  output logic              set_req,
  output logic              clr_req,
  output acc_kind_e         kind
);
  localparam logic [WIN_W:0] LIMIT = (WIN_W + 1)'(MEM_SIZE);

  logic in_range;

  always_comb begin
    in_range = {1'b0, io_addr[WIN_W-1:0]} < LIMIT;
    set_req  = io_wr && !bank_on && (io_addr[PORT_W-1:0] == EN_PORT);
    clr_req  = io_rd && bank_on && (io_addr == DIS_ADDR);
    kind     = ACC_NONE;
    if (io_wr) begin
      if (bank_on)       kind = in_range ? ACC_VRAM : ACC_DROP;
      else if (!set_req) kind = ACC_PERIPH;
    end
  end
endmodule

// File: rtl/vw_mode_reg.sv
module vw_mode_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic bank_on
);
  logic flag_q, flag_d, flag_en;

  always_comb begin
    flag_en = set_req || clr_req;
    flag_d  = set_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign bank_on = flag_q;

  p_set_on_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req && !flag_q) |=> flag_q);
  p_clear_on_disable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> !flag_q);
  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_req && !clr_req) |=> $stable(flag_q));
endmodule

// File: rtl/vw_vram_port.sv
module vw_vram_port
  import vw_pkg::*;
#(
  parameter int unsigned WIN_W    = VW_WIN_W,
  parameter int unsigned DATA_W   = VW_DATA_W,
  parameter int unsigned MEM_SIZE = VW_MEM_SIZE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  acc_kind_e         kind,
  input  logic              bank_on,
  input  logic [WIN_W-1:0]  win_addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              vram_we,
  output logic [WIN_W-1:0]  vram_addr,
  output logic [DATA_W-1:0] vram_wdata,
  output logic              vram_ovf
);
  localparam logic [WIN_W:0] LIMIT = (WIN_W + 1)'(MEM_SIZE);

  logic              we_q, we_d;
  logic              ovf_q, ovf_d;
  logic              bus_en;
  logic [WIN_W-1:0]  addr_q;
  logic [DATA_W-1:0] data_q;

  always_comb begin
    we_d   = (kind == ACC_VRAM);
    bus_en = we_d;
    ovf_d  = ovf_q || (kind == ACC_DROP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q  <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      we_q  <= we_d;
      ovf_q <= ovf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (bus_en) begin
      addr_q <= win_addr;
      data_q <= wdata;
    end
  end

  assign vram_we    = we_q;
  assign vram_addr  = addr_q;
  assign vram_wdata = data_q;
  assign vram_ovf   = ovf_q;

  p_vram_only_banked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_on |=> !we_q);
  p_vram_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |-> ({1'b0, addr_q} < LIMIT));
  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);
endmodule

// File: rtl/vw_periph_port.sv
module vw_periph_port
  import vw_pkg::*;
#(
  parameter int unsigned PORT_W = VW_PORT_W,
  parameter int unsigned DATA_W = VW_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  acc_kind_e         kind,
  input  logic              bank_on,
  input  logic [PORT_W-1:0] port,
  input  logic [DATA_W-1:0] wdata,
  output logic              periph_we,
  output logic [PORT_W-1:0] periph_port,
  output logic [DATA_W-1:0] periph_wdata
);
  logic              we_q, we_d;
  logic [PORT_W-1:0] port_q;
  logic [DATA_W-1:0] data_q;

  always_comb we_d = (kind == ACC_PERIPH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_q <= 1'b0;
    else        we_q <= we_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q <= '0;
      data_q <= '0;
    end else if (we_d) begin
      port_q <= port;
      data_q <= wdata;
    end
  end

  assign periph_we    = we_q;
  assign periph_port  = port_q;
  assign periph_wdata = data_q;

  p_no_periph_banked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bank_on |=> !we_q);
endmodule

// File: rtl/vram_io_window.sv
module vram_io_window
  import vw_pkg::*;
#(
  parameter int unsigned ADDR_W   = VW_ADDR_W,
  parameter int unsigned DATA_W   = VW_DATA_W,
  parameter int unsigned PORT_W   = VW_PORT_W,
  parameter int unsigned WIN_W    = VW_WIN_W,
  parameter int unsigned MEM_SIZE = VW_MEM_SIZE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              io_rd,
  input  logic              io_wr,
  output logic              vram_we,
  output logic [WIN_W-1:0]  vram_addr,
  output logic [DATA_W-1:0] vram_wdata,
  output logic              periph_we,
  output logic [PORT_W-1:0] periph_port,
  output logic [DATA_W-1:0] periph_wdata,
  output logic              bank_on,
  output logic              vram_ovf
);
  logic      rst_meta, rst_sync;
  logic      set_req, clr_req;
  acc_kind_e kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  vw_decode #(
    .ADDR_W(ADDR_W), .PORT_W(PORT_W), .WIN_W(WIN_W), .MEM_SIZE(MEM_SIZE)
  ) u_dec (
    .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr), .bank_on(bank_on),
    .set_req(set_req), .clr_req(clr_req), .kind(kind)
  );

  vw_mode_reg u_mode (
    .clk(clk), .rst_n(rst_sync), .set_req(set_req), .clr_req(clr_req),
    .bank_on(bank_on)
  );

  vw_vram_port #(
    .WIN_W(WIN_W), .DATA_W(DATA_W), .MEM_SIZE(MEM_SIZE)
  ) u_vram (
    .clk(clk), .rst_n(rst_sync), .kind(kind), .bank_on(bank_on),
    .win_addr(io_addr[WIN_W-1:0]), .wdata(io_wdata),
    .vram_we(vram_we), .vram_addr(vram_addr), .vram_wdata(vram_wdata),
    .vram_ovf(vram_ovf)
  );

  vw_periph_port #(
    .PORT_W(PORT_W), .DATA_W(DATA_W)
  ) u_per (
    .clk(clk), .rst_n(rst_sync), .kind(kind), .bank_on(bank_on),
    .port(io_addr[PORT_W-1:0]), .wdata(io_wdata),
    .periph_we(periph_we), .periph_port(periph_port), .periph_wdata(periph_wdata)
  );

  p_excl_strobes_r9: assert property (@(posedge clk) disable iff (!rst_sync)
    !(vram_we && periph_we));
  p_read_no_strobe_r9: assert property (@(posedge clk) disable iff (!rst_sync)
    (io_rd && !io_wr) |=> (!vram_we && !periph_we));
endmodule

// File: tb/sim_vram_io_window.sv
module sim_vram_io_window;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] io_addr;
  logic [7:0]  io_wdata;
  logic        io_rd, io_wr;
  logic        vram_we, periph_we, bank_on, vram_ovf;
  logic [14:0] vram_addr;
  logic [7:0]  vram_wdata, periph_port, periph_wdata;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;
  logic m_bank, m_ovf;

  always #2 clk = ~clk;

  vram_io_window u0 (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rd(io_rd), .io_wr(io_wr), .vram_we(vram_we), .vram_addr(vram_addr),
    .vram_wdata(vram_wdata), .periph_we(periph_we), .periph_port(periph_port),
    .periph_wdata(periph_wdata), .bank_on(bank_on), .vram_ovf(vram_ovf)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d, input string req);
    logic e_vram, e_per;
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    e_vram = 1'b0; e_per = 1'b0;
    if (m_bank) begin
      if ({1'b0, a[14:0]} < 16'd20480) e_vram = 1'b1;
      else m_ovf = 1'b1;
    end else if (a[7:0] == 8'hC8) m_bank = 1'b1;
    else e_per = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    chk({req, " vram_we"}, 32'(vram_we), 32'(e_vram));
    chk({req, " periph_we"}, 32'(periph_we), 32'(e_per));
    chk({req, " bank_on"}, 32'(bank_on), 32'(m_bank));
    chk({req, " vram_ovf"}, 32'(vram_ovf), 32'(m_ovf));
    if (e_vram) begin
      chk({req, " vram_addr"}, 32'(vram_addr), 32'(a[14:0]));
      chk({req, " vram_wdata"}, 32'(vram_wdata), 32'(d));
    end
    if (e_per) begin
      chk({req, " periph_port"}, 32'(periph_port), 32'(a[7:0]));
      chk({req, " periph_wdata"}, 32'(periph_wdata), 32'(d));
    end
  endtask

  task automatic io_read(input logic [15:0] a, input string req);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    if (m_bank && a == 16'h7FFF) m_bank = 1'b0;
    @(negedge clk);
    io_rd = 1'b0;
    chk({req, " bank_on"}, 32'(bank_on), 32'(m_bank));
    chk({req, " R9 vram_we"}, 32'(vram_we), 32'd0);
    chk({req, " R9 periph_we"}, 32'(periph_we), 32'd0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; io_addr = '0; io_wdata = '0; io_rd = 1'b0; io_wr = 1'b0;
    m_bank = 1'b0; m_ovf = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset bank_on", 32'(bank_on), 32'd0);
    chk("R1 reset vram_we", 32'(vram_we), 32'd0);
    chk("R1 reset periph_we", 32'(periph_we), 32'd0);
    chk("R1 reset vram_ovf", 32'(vram_ovf), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release bank_on", 32'(bank_on), 32'd0);
    chk("R1 after release vram_ovf", 32'(vram_ovf), 32'd0);

    // R8: every low port except the enable one, each with its own upper byte
    for (int p = 0; p < 256; p++) begin
      if (p != 8'hC8)
        io_write({8'((p * 53 + 7) & 8'hFF), 8'(p)}, 8'(p ^ 8'h5A), "R8 passthrough");
    end
    // R6: the disable read and others have no effect while the mode is off
    io_read(16'h7FFF, "R6 disable read while off");
    io_read(16'h00C8, "R6 other read while off");

    // R2: the enable write ignores the upper byte and the data
    io_write(16'h12C8, 8'hA5, "R2 enable");

    // R3: stepped sweep of the legal window, bit 15 toggled on odd steps
    for (int i = 0; i < 20480; i += 61) begin
      io_write(16'(i) | ((i & 1) != 0 ? 16'h8000 : 16'h0000), 8'(i * 7), "R3 banked sweep");
    end
    io_write(16'h0000, 8'h11, "R3 edge 0x0000");
    io_write(16'h01FF, 8'h22, "R3 palette end");
    io_write(16'h0200, 8'h33, "R3 pixel start");
    io_write(16'hCFFF, 8'h44, "R3 edge 0x4FFF with bit15");
    // R4: the enable port is an ordinary video write while banked
    io_write(16'h00C8, 8'h55, "R4 enable port banked");
    io_write(16'hFFC8, 8'h66, "R4 enable port banked high");

    // R5: near-miss reads keep the mode on
    io_read(16'h7FFE, "R5 near miss");
    io_read(16'hFFFF, "R5 bit15 miss");
    io_read(16'h00C8, "R5 other read");

    // R7: discarded writes, sticky overflow
    io_write(16'h5000, 8'h77, "R7 first out of range");
    io_write(16'h7FFF, 8'h78, "R7 top of window");
    io_write(16'hD000, 8'h79, "R7 out of range bit15");
    io_write(16'h0100, 8'h7A, "R7 legal after overflow");

    // R5: exact disable read clears the mode
    io_read(16'h7FFF, "R5 disable");
    io_write(16'h0020, 8'h81, "R8 after disable");
    io_write(16'h34C8, 8'h00, "R2 re-enable");
    io_write(16'h4000, 8'h82, "R3 after re-enable");
    io_read(16'h7FFF, "R5 disable again");
    io_read(16'h7FFF, "R6 second disable read");
    chk("R7 overflow still set", 32'(vram_ovf), 32'd1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule